// File: doc/BRIEF.md
# Memory Request Header Generator

This block turns one memory read or memory write request into the header dwords of a transaction packet. A request gives a byte start address of up to 64 bits, a byte count, a write flag, a digest flag, a 16-bit requester identity and an 8-bit tag. From these the block picks the short (3-dword) or long (4-dword) header and sets the format and type codes. It also works out the dword length that the unaligned byte range spans, and the byte enables for the first and last dwords of that range.

The header goes out one dword per cycle on a valid/ready stream. The final dword is flagged. The block takes no new request until the last dword has been accepted. A request with a zero byte count, or one that spans more dwords than the largest allowed payload, is dropped. No header is sent for it, and an error strobe marks the drop. Payload movement, CRC work, credits and splitting of large requests are left to neighbouring blocks.

Top module: `memreq_hdr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, hdr_valid is 0 and req_err is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. In the next cycle hdr_valid is 1 with header dword 0. Each dword is held, unchanged, until a cycle with hdr_ready at 1. hdr_last is 1 on the final dword only. req_ready is 0 while dwords are pending and is 1 again in the cycle after the final transfer.
- R3: When req_addr[63:32] is zero the header is 3 dwords. Otherwise it is 4 dwords, and dword 2 carries req_addr[63:32].
- R4: Dword 0 bits [31:29] hold the format: 000 for a short read, 001 for a long read, 010 for a short write and 011 for a long write. Bits [28:24] hold type 00000.
- R5: The last header dword carries req_addr[31:2] in bits [31:2], with bits [1:0] at 0.
- R6: Dword 0 bits [9:0] give the number of dwords spanned by bytes req_addr through req_addr+req_bytes-1. A span of 1024 is written as 0.
- R7: Dword 1 bits [3:0] are the first-dword enables. Bit i is 1 exactly when byte i of the first spanned dword lies inside the range (bit 0 is the lowest address).
- R8: Dword 1 bits [7:4] are the last-dword enables, formed in the same way for the final spanned dword. They are 0000 when the span is one dword.
- R9: Dword 0 bit 15 equals req_digest.
- R10: Dword 1 bits [31:16] equal req_id and bits [15:8] equal req_tag. Dword 0 bits [23:16] and [14:10] are 0.
- R11: A taken request with req_bytes of 0, or a span above 1024 dwords, raises req_err for exactly the next cycle. No header dword is sent for it, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 64 | Byte start address |
| req_bytes | input | 13 | Byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| req_digest | input | 1 | A digest dword will follow the packet |
| req_id | input | 16 | Requester identity |
| req_tag | input | 8 | Request tag |
| hdr_valid | output | 1 | Header dword present |
| hdr_ready | input | 1 | Downstream takes the dword |
| hdr_data | output | 32 | Header dword, first header byte in bits [31:24] |
| hdr_last | output | 1 | Final header dword |
| req_err | output | 1 | Request was dropped |

## Verification
Requests are placed at every byte offset within a dword, with byte counts chosen so that:
- one run stays inside a single dword;
- one run crosses several dwords and ends on a lowest-byte boundary;
- one run fills exactly 1024 dwords from an unaligned start.

Together these separate the first-enable, last-enable and length arithmetic from one another and check the 1024-to-0 wrap. Both address halves are used, so a wrong choice between the 3-dword and 4-dword forms shows up in the dword count, the format bits and the placement of the upper address. The bench also sends requests one dword over the limit and with zero bytes, and stalls the output partway through a header. These separate the drop path and the hold behaviour from normal emission.

// File: rtl/memreq_pkg.sv
package memreq_pkg;
  localparam int MAX_DW  = 1024;
  localparam int LEN_W   = $clog2(MAX_DW);
  localparam int CNT_W   = $clog2(MAX_DW * 4) + 1;
  localparam int SPAN_W  = CNT_W + 1;
  localparam int ADDR_W  = 64;
  localparam int DW_W    = 32;
  localparam int ID_W    = 16;
  localparam int TAG_W   = 8;
  localparam int BE_W    = 4;
  localparam int TYPE_W  = 5;
  localparam int FMT_W   = 3;

  localparam logic [TYPE_W-1:0] TYPE_MEM = 5'b00000;

  typedef struct packed {
    logic [FMT_W-1:0]  fmt;
    logic              td;
    logic [LEN_W-1:0]  len;
    logic [BE_W-1:0]   fbe;
    logic [BE_W-1:0]   lbe;
    logic [ID_W-1:0]   rid;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
  } hdr_fields_t;

  // dwords touched by a byte run starting at offset off
  function automatic logic [SPAN_W-1:0] span_dwords(logic [1:0] off,
                                                    logic [CNT_W-1:0] nbytes);
    logic [SPAN_W-1:0] s;
    s = SPAN_W'(off) + SPAN_W'(nbytes) + SPAN_W'(3);
    return s >> 2;
  endfunction

  // position of the last byte measured from the start of the first dword
  function automatic logic [SPAN_W-1:0] end_pos(logic [1:0] off,
                                                logic [CNT_W-1:0] nbytes);
    return SPAN_W'(off) + SPAN_W'(nbytes) - SPAN_W'(1);
  endfunction

  function automatic logic [BE_W-1:0] calc_first_be(logic [1:0] off,
                                                    logic [CNT_W-1:0] nbytes);
    logic [SPAN_W-1:0] ep;
    logic [BE_W-1:0]   m;
    ep = end_pos(off, nbytes);
    m  = 4'hF << off;
    if (ep < SPAN_W'(4)) m = m & (4'hF >> (2'd3 - ep[1:0]));
    return m;
  endfunction

  function automatic logic [BE_W-1:0] calc_last_be(logic [1:0] off,
                                                   logic [CNT_W-1:0] nbytes);
    logic [SPAN_W-1:0] ep;
    ep = end_pos(off, nbytes);
    if (ep < SPAN_W'(4)) return '0;
    return 4'hF >> (2'd3 - ep[1:0]);
  endfunction

  function automatic logic [1:0] final_index(logic long_form);
    return long_form ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/memreq_field_calc.sv
module memreq_field_calc
  import memreq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              write,
  input  logic              digest,
  input  logic [ID_W-1:0]   rid,
  input  logic [TAG_W-1:0]  tag,
  output hdr_fields_t       fields,
  output logic              bad
);
  logic [SPAN_W-1:0] ndw;
  logic              long_form;

  always_comb begin
    ndw       = span_dwords(addr[1:0], nbytes);
    long_form = |addr[ADDR_W-1:DW_W];
    bad       = (nbytes == '0) || (ndw > SPAN_W'(MAX_DW));
    fields.fmt  = {1'b0, write, long_form};
    fields.td   = digest;
    fields.len  = ndw[LEN_W-1:0];
    fields.fbe  = calc_first_be(addr[1:0], nbytes);
    fields.lbe  = calc_last_be(addr[1:0], nbytes);
    fields.rid  = rid;
    fields.tag  = tag;
    fields.addr = {addr[ADDR_W-1:2], 2'b00};
  end
endmodule

// File: rtl/memreq_emit_ctrl.sv
module memreq_emit_ctrl
  import memreq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  hdr_fields_t fields_in,
  input  logic        bad_in,
  input  logic        hdr_ready,
  output logic        req_ready,
  output logic        hdr_valid,
  output logic        hdr_last,
  output logic        req_err,
  output logic [1:0]  idx,
  output hdr_fields_t held
);
  logic busy;
  logic take;
  logic step;

  assign req_ready = !busy;
  assign hdr_valid = busy;
  assign take      = req_valid && req_ready;
  assign step      = hdr_valid && hdr_ready;
  assign hdr_last  = busy && (idx == final_index(held.fmt[0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      req_err <= 1'b0;
      held    <= '0;
    end else begin
      req_err <= take && bad_in;
      if (take && !bad_in) begin
        held <= fields_in;
        busy <= 1'b1;
        idx  <= '0;
      end else if (step) begin
        idx <= idx + 2'd1;
        if (hdr_last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/memreq_hdr_pack.sv
module memreq_hdr_pack
  import memreq_pkg::*;
(
  input  hdr_fields_t      held,
  input  logic [1:0]       idx,
  output logic [DW_W-1:0]  dword
);
  logic [DW_W-1:0] addr_lo;
  logic [DW_W-1:0] addr_hi;

  assign addr_lo = held.addr[DW_W-1:0];
  assign addr_hi = held.addr[ADDR_W-1:DW_W];

  always_comb begin
    unique case (idx)
      2'd0: dword = {held.fmt, TYPE_MEM, 8'h00, held.td, 5'b00000, held.len};
      2'd1: dword = {held.rid, held.tag, held.lbe, held.fbe};
      2'd2: dword = held.fmt[0] ? addr_hi : addr_lo;
      default: dword = addr_lo;
    endcase
  end
endmodule

// File: rtl/memreq_hdr_gen.sv
module memreq_hdr_gen
  import memreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              req_write,
  input  logic              req_digest,
  input  logic [ID_W-1:0]   req_id,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [DW_W-1:0]   hdr_data,
  output logic              hdr_last,
  output logic              req_err
);
  hdr_fields_t fields;
  hdr_fields_t held;
  logic        req_bad;
  logic [1:0]  idx;

  // named events for the checker
  logic req_fire;
  logic hdr_fire;
  logic hdr_first;

  assign req_fire  = req_valid && req_ready;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign hdr_first = hdr_valid && (idx == 2'd0);

  memreq_field_calc u_calc (
    .addr   (req_addr),
    .nbytes (req_bytes),
    .write  (req_write),
    .digest (req_digest),
    .rid    (req_id),
    .tag    (req_tag),
    .fields (fields),
    .bad    (req_bad)
  );

  memreq_emit_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .fields_in (fields),
    .bad_in    (req_bad),
    .hdr_ready (hdr_ready),
    .req_ready (req_ready),
    .hdr_valid (hdr_valid),
    .hdr_last  (hdr_last),
    .req_err   (req_err),
    .idx       (idx),
    .held      (held)
  );

  memreq_hdr_pack u_pack (
    .held  (held),
    .idx   (idx),
    .dword (hdr_data)
  );
endmodule

// File: rtl/memreq_hdr_gen_chk.sv
module memreq_hdr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic [31:0] hdr_data,
  input logic        hdr_last,
  input logic        req_err,
  input logic        req_fire,
  input logic        hdr_fire,
  input logic        hdr_first,
  input logic        req_bad
);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data) && $stable(hdr_last));

  assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !req_ready);

  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && hdr_last |=> !hdr_valid && req_ready);

  assert_type_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_first |-> (hdr_data[28:24] == 5'b00000) && !hdr_data[31]);

  assert_addr_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_last |-> hdr_data[1:0] == 2'b00);

  assert_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_bad |=> req_err && !hdr_valid && req_ready);

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_fire));
endmodule

bind memreq_hdr_gen memreq_hdr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .hdr_data  (hdr_data),
  .hdr_last  (hdr_last),
  .req_err   (req_err),
  .req_fire  (req_fire),
  .hdr_fire  (hdr_fire),
  .hdr_first (hdr_first),
  .req_bad   (req_bad)
);

// File: tb/memreq_hdr_gen_test.sv
`timescale 1ns/1ps
module memreq_hdr_gen_test;
  import memreq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_bytes = '0;
  logic              req_write = 1'b0;
  logic              req_digest = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              hdr_valid;
  logic              hdr_ready = 1'b1;
  logic [DW_W-1:0]   hdr_data;
  logic              hdr_last;
  logic              req_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  memreq_hdr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_write(req_write),
    .req_digest(req_digest), .req_id(req_id), .req_tag(req_tag),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .hdr_last(hdr_last), .req_err(req_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
    chk("R1 hdr_valid in reset", 64'(hdr_valid), 64'd0);
    chk("R1 req_err in reset", 64'(req_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
    chk("R1 hdr_valid after reset", 64'(hdr_valid), 64'd0);
  endtask

  // one good request; stall_at picks a dword to hold back for two cycles (-1 none)
  task automatic t_request(input string name, input logic [63:0] a, input int nb,
                           input bit wr, input bit dg, input logic [15:0] id,
                           input logic [7:0] tg, input int stall_at);
    logic [63:0] last_b;
    logic [63:0] ndw;
    logic [63:0] b;
    logic [3:0]  fbe;
    logic [3:0]  lbe;
    bit          lng;
    int          n;
    bit          seen_last;
    logic [31:0] got [4];
    logic [31:0] snap;
    last_b = a + 64'(nb) - 64'd1;
    ndw    = (last_b >> 2) - (a >> 2) + 64'd1;
    lng    = (a[63:32] != 32'd0);
    fbe = '0;
    lbe = '0;
    for (int i = 0; i < 4; i++) begin
      b = {a[63:2], 2'b00} + 64'(i);
      if (b >= a && b <= last_b) fbe[i] = 1'b1;
      b = {last_b[63:2], 2'b00} + 64'(i);
      if (ndw > 1 && b <= last_b) lbe[i] = 1'b1;
    end

    @(negedge clk);
    req_addr = a; req_bytes = CNT_W'(nb); req_write = wr; req_digest = dg;
    req_id = id; req_tag = tg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({name, " R2 ready low after take"}, 64'(req_ready), 64'd0);
    n = 0;
    seen_last = 1'b0;
    for (int k = 0; k < 4; k++) got[k] = '0;
    while (!seen_last && n < 4) begin
      if (!hdr_valid) begin
        chk({name, " R2 hdr_valid"}, 64'(hdr_valid), 64'd1);
        break;
      end
      if (n == stall_at) begin
        snap = hdr_data;
        hdr_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk({name, " R2 held valid"}, 64'(hdr_valid), 64'd1);
        chk({name, " R2 held data"}, 64'(hdr_data), 64'(snap));
        hdr_ready = 1'b1;
      end
      got[n] = hdr_data;
      seen_last = hdr_last;
      n++;
      @(negedge clk);
    end
    chk({name, " R2 ready back"}, 64'(req_ready), 64'd1);
    chk({name, " R2 valid off"}, 64'(hdr_valid), 64'd0);
    chk({name, " R3 dword count"}, 64'(n), lng ? 64'd4 : 64'd3);
    chk({name, " R4 format"}, 64'(got[0][31:29]), 64'({1'b0, wr, lng}));
    chk({name, " R4 type"}, 64'(got[0][28:24]), 64'd0);
    chk({name, " R6 length"}, 64'(got[0][9:0]), 64'(ndw[9:0]));
    chk({name, " R9 digest"}, 64'(got[0][15]), 64'(dg));
    chk({name, " R10 zero bits"}, 64'({got[0][23:16], got[0][14:10]}), 64'd0);
    chk({name, " R10 id"}, 64'(got[1][31:16]), 64'(id));
    chk({name, " R10 tag"}, 64'(got[1][15:8]), 64'(tg));
    chk({name, " R7 first be"}, 64'(got[1][3:0]), 64'(fbe));
    chk({name, " R8 last be"}, 64'(got[1][7:4]), 64'(lbe));
    if (lng) begin
      chk({name, " R3 upper addr"}, 64'(got[2]), 64'(a[63:32]));
      chk({name, " R5 lower addr"}, 64'(got[3]), 64'({a[31:2], 2'b00}));
    end else begin
      chk({name, " R5 lower addr"}, 64'(got[2]), 64'({a[31:2], 2'b00}));
    end
  endtask

  task automatic t_reject(input string name, input logic [63:0] a, input int nb);
    @(negedge clk);
    req_addr = a; req_bytes = CNT_W'(nb); req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({name, " R11 err raised"}, 64'(req_err), 64'd1);
    chk({name, " R11 no header"}, 64'(hdr_valid), 64'd0);
    chk({name, " R11 ready stays"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk({name, " R11 err one cycle"}, 64'(req_err), 64'd0);
    chk({name, " R11 still no header"}, 64'(hdr_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_request("aligned read",       64'h1000, 4, 1'b0, 1'b0, 16'hA1B2, 8'h05, -1);
    t_request("multi dword write",  64'h2002, 11, 1'b1, 1'b0, 16'h0102, 8'h7E, 1);
    t_request("single partial",     64'h0101, 2, 1'b0, 1'b1, 16'hFFFF, 8'h00, -1);
    t_request("long digest read",   64'h0000_0012_3456_7893, 5, 1'b0, 1'b1, 16'h1234, 8'hC3, 2);
    t_request("max aligned write",  64'h8000_0000_0000_0000, 4096, 1'b1, 1'b0, 16'h0042, 8'h11, -1);
    t_request("max unaligned read", 64'h0000_0000_0000_3003, 4093, 1'b0, 1'b0, 16'h5A5A, 8'hFE, 0);
    t_reject("over limit", 64'h3003, 4094);
    t_reject("zero bytes", 64'h4000, 0);
    t_request("after reject",       64'h5007, 1, 1'b1, 1'b1, 16'h0F0F, 8'h33, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule